// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block holds the register state for one descriptor-driven DMA channel. Software reaches it through a 32-bit word port. A separate channel engine, which fetches descriptors and moves data, connects to it through a few single-cycle pulse inputs and level outputs. The block keeps the channel status word and the command pointer. It also stores the condition-select registers and the auxiliary address registers the engine needs.

Software never writes the status word directly. It writes a control word instead: the upper half is a per-bit enable mask and the lower half carries the new values. Any subset of status bits can therefore change in one atomic write, with no read-modify-write. Stopping and resetting the channel both use this mechanism. In each case software polls the status word until the engine has acknowledged.

Register words carry their least significant byte on bits 7:0 of the data port. Word index 0 is control, 1 is status, 2 and 3 are the upper and lower command pointer halves, 4 to 9 and 11 to 12 are plain storage registers, and 10 and 13 to 15 are reserved.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset every register reads zero, and runOut, pauseOut, flushReq and wakePulse are low.
- R2: Word indices 4 to 9, 11 and 12 store and read back a full 32-bit write. Indices 0, 10, 13, 14 and 15 always read zero and ignore writes. A write to index 1 (status) has no effect.
- R3: A write to index 0 changes only the status bits whose enable bit (data bit 16+n) is 1, each to its value bit (data bit n). The status layout is: RUN bit 15, PAUSE 14, FLUSH 13, WAKE 12, DEAD 11, ACTIVE 10, BT 8, device status 7:0, and bit 9 always reads 0.
- R4: Software can clear ACTIVE, DEAD and BT through a masked write but cannot set them. A masked value of 1 for those bits leaves them unchanged.
- R5: engActiveSet sets ACTIVE only while RUN is 1. engIdle clears ACTIVE. engDeadSet sets DEAD and clears ACTIVE.
- R6: flushReq follows the FLUSH bit. flushDone clears FLUSH on the next edge and takes precedence over a software set of FLUSH in the same cycle.
- R7: A masked write of WAKE=1 raises WAKE and wakePulse for exactly one cycle. Both then return to 0 by themselves.
- R8: A control write of 0xA0000000 (enable RUN and FLUSH, values zero) clears RUN and FLUSH on the next edge. ACTIVE stays set until the engine pulses engIdle.
- R9: A control write of 0xFC000000 clears RUN, PAUSE, FLUSH, WAKE, DEAD and ACTIVE on the next edge. BT and device status are left unchanged.
- R10: Writes to word indices 2 and 3 take effect only while RUN and ACTIVE are both 0. At all other times they are ignored.
- R11: engBtSet sets BT. engDevWe loads engDevData into the device status field.
- R12: runOut, pauseOut, cmdPtr, irqSel, brSel and waitSel present the current register contents to the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| engActiveSet | input | 1 | Engine pulse: descriptor processing started |
| engIdle | input | 1 | Engine pulse: channel stopped processing |
| engDeadSet | input | 1 | Engine pulse: bus error |
| engBtSet | input | 1 | Engine pulse: branch taken |
| engDevWe | input | 1 | Engine pulse: load device status |
| engDevData | input | 8 | Device status value |
| flushDone | input | 1 | Engine pulse: flush write-back complete |
| runOut | output | 1 | RUN bit |
| pauseOut | output | 1 | PAUSE bit |
| flushReq | output | 1 | FLUSH bit, a flush request to the engine |
| wakePulse | output | 1 | One-cycle request to re-fetch the descriptor at cmdPtr |
| cmdPtr | output | 64 | Command pointer, upper and lower halves |
| irqSel | output | 32 | Interrupt condition select |
| brSel | output | 32 | Branch condition select |
| waitSel | output | 32 | Wait condition select |

## Verification
Masked control writes are applied with enable masks that select one bit, a whole field, nothing at all, and the exact stop and reset masks. This separates bits that take the written value from bits that must hold. Clear-only bits receive writes with value 1 while they are both set and clear, which shows whether software could set them. Engine pulses arrive with RUN both high and low, and a flush acknowledge lands in the same cycle as a software flush set, which exposes any precedence error. Command pointer writes are attempted while running, while stopped but still active, and while idle, so each lock condition is tested separately.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned HALF_W    = WORD_W / 2;
  localparam int unsigned MAP_WORDS = 16;
  localparam int unsigned IDX_W     = $clog2(MAP_WORDS);
  localparam int unsigned DEV_W     = 8;

  localparam int unsigned BIT_RUN    = 15;
  localparam int unsigned BIT_PAUSE  = 14;
  localparam int unsigned BIT_FLUSH  = 13;
  localparam int unsigned BIT_WAKE   = 12;
  localparam int unsigned BIT_DEAD   = 11;
  localparam int unsigned BIT_ACTIVE = 10;
  localparam int unsigned BIT_RSVD   = 9;
  localparam int unsigned BIT_BT     = 8;

  localparam logic [IDX_W-1:0] IDX_CTL     = 4'd0;
  localparam logic [IDX_W-1:0] IDX_STAT    = 4'd1;
  localparam logic [IDX_W-1:0] IDX_PTR_HI  = 4'd2;
  localparam logic [IDX_W-1:0] IDX_PTR_LO  = 4'd3;
  localparam int unsigned      IDX_IRQSEL  = 4;
  localparam int unsigned      IDX_BRSEL   = 5;
  localparam int unsigned      IDX_WAITSEL = 6;

  // word indices backed by plain storage
  localparam logic [MAP_WORDS-1:0] PLAIN_MASK = 16'h1BF0;
  // status bits software may only clear
  localparam logic [HALF_W-1:0] CLR_ONLY_MASK = 16'h0D00;

  typedef struct packed {
    logic                 ctlWr;
    logic [HALF_W-1:0]    mask;
    logic [HALF_W-1:0]    val;
    logic                 ptrHiWr;
    logic                 ptrLoWr;
    logic [MAP_WORDS-1:0] plainWr;
  } csrStrobes_t;
endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
(
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regAddr,
  input  logic [WORD_W-1:0] regWrData,
  input  logic              runNow,
  input  logic              activeNow,
  output csrStrobes_t       strb
);
  logic ptrOpen;
  assign ptrOpen = !runNow && !activeNow;

  always_comb begin
    strb = '0;
    if (regWrEn) begin
      unique case (regAddr)
        IDX_CTL: begin
          strb.ctlWr = 1'b1;
          strb.mask  = regWrData[WORD_W-1:HALF_W];
          strb.val   = regWrData[HALF_W-1:0];
        end
        IDX_STAT:   ;
        IDX_PTR_HI: strb.ptrHiWr = ptrOpen;
        IDX_PTR_LO: strb.ptrLoWr = ptrOpen;
        default:    strb.plainWr[regAddr] = PLAIN_MASK[regAddr];
      endcase
    end
  end
endmodule

// File: rtl/dma_csr_data.sv
module dma_csr_data
  import dma_csr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  csrStrobes_t         strb,
  input  logic [WORD_W-1:0]   regWrData,
  input  logic [IDX_W-1:0]    regAddr,
  input  logic                engActiveSet,
  input  logic                engIdle,
  input  logic                engDeadSet,
  input  logic                engBtSet,
  input  logic                engDevWe,
  input  logic [DEV_W-1:0]    engDevData,
  input  logic                flushDone,
  output logic [HALF_W-1:0]   statOut,
  output logic [2*WORD_W-1:0] ptrOut,
  output logic [WORD_W-1:0]   irqSelOut,
  output logic [WORD_W-1:0]   brSelOut,
  output logic [WORD_W-1:0]   waitSelOut,
  output logic [WORD_W-1:0]   rdData
);
  logic [HALF_W-1:0] statQ, statNext;
  logic [WORD_W-1:0] ptrHiQ, ptrLoQ;
  logic [WORD_W-1:0] plainQ [MAP_WORDS];

  always_comb begin
    statNext           = statQ;
    statNext[BIT_WAKE] = 1'b0;
    if (strb.ctlWr) begin
      for (int b = 0; b < HALF_W; b++) begin
        if (strb.mask[b]) begin
          if (CLR_ONLY_MASK[b]) begin
            if (!strb.val[b]) statNext[b] = 1'b0;
          end else begin
            statNext[b] = strb.val[b];
          end
        end
      end
    end
    // engine events take precedence over software
    if (flushDone) statNext[BIT_FLUSH] = 1'b0;
    if (engIdle) statNext[BIT_ACTIVE] = 1'b0;
    if (engActiveSet && statQ[BIT_RUN]) statNext[BIT_ACTIVE] = 1'b1;
    if (engDeadSet) begin
      statNext[BIT_DEAD]   = 1'b1;
      statNext[BIT_ACTIVE] = 1'b0;
    end
    if (engBtSet) statNext[BIT_BT] = 1'b1;
    if (engDevWe) statNext[DEV_W-1:0] = engDevData;
    statNext[BIT_RSVD] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= statNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrHiQ <= '0;
      ptrLoQ <= '0;
    end else begin
      if (strb.ptrHiWr) ptrHiQ <= regWrData;
      if (strb.ptrLoWr) ptrLoQ <= regWrData;
    end
  end

  for (genvar g = 0; g < MAP_WORDS; g++) begin : gWord
    if (PLAIN_MASK[g]) begin : gStore
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               q <= '0;
        else if (strb.plainWr[g]) q <= regWrData;
      end
      assign plainQ[g] = q;
    end else begin : gZero
      assign plainQ[g] = '0;
    end
  end

  always_comb begin
    unique case (regAddr)
      IDX_STAT:   rdData = {{(WORD_W-HALF_W){1'b0}}, statQ};
      IDX_PTR_HI: rdData = ptrHiQ;
      IDX_PTR_LO: rdData = ptrLoQ;
      default:    rdData = plainQ[regAddr];
    endcase
  end

  assign statOut    = statQ;
  assign ptrOut     = {ptrHiQ, ptrLoQ};
  assign irqSelOut  = plainQ[IDX_IRQSEL];
  assign brSelOut   = plainQ[IDX_BRSEL];
  assign waitSelOut = plainQ[IDX_WAITSEL];
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [IDX_W-1:0]    regAddr,
  input  logic [WORD_W-1:0]   regWrData,
  output logic [WORD_W-1:0]   regRdData,
  input  logic                engActiveSet,
  input  logic                engIdle,
  input  logic                engDeadSet,
  input  logic                engBtSet,
  input  logic                engDevWe,
  input  logic [DEV_W-1:0]    engDevData,
  input  logic                flushDone,
  output logic                runOut,
  output logic                pauseOut,
  output logic                flushReq,
  output logic                wakePulse,
  output logic [2*WORD_W-1:0] cmdPtr,
  output logic [WORD_W-1:0]   irqSel,
  output logic [WORD_W-1:0]   brSel,
  output logic [WORD_W-1:0]   waitSel
);
  csrStrobes_t       strb;
  logic [HALF_W-1:0] statReg;

  dma_csr_ctrl u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .runNow    (statReg[BIT_RUN]),
    .activeNow (statReg[BIT_ACTIVE]),
    .strb      (strb)
  );

  dma_csr_data u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .regWrData    (regWrData),
    .regAddr      (regAddr),
    .engActiveSet (engActiveSet),
    .engIdle      (engIdle),
    .engDeadSet   (engDeadSet),
    .engBtSet     (engBtSet),
    .engDevWe     (engDevWe),
    .engDevData   (engDevData),
    .flushDone    (flushDone),
    .statOut      (statReg),
    .ptrOut       (cmdPtr),
    .irqSelOut    (irqSel),
    .brSelOut     (brSel),
    .waitSelOut   (waitSel),
    .rdData       (regRdData)
  );

  assign runOut    = statReg[BIT_RUN];
  assign pauseOut  = statReg[BIT_PAUSE];
  assign flushReq  = statReg[BIT_FLUSH];
  assign wakePulse = statReg[BIT_WAKE];
endmodule

// File: rtl/dma_csr_chk.sv
module dma_csr_chk
  import dma_csr_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [IDX_W-1:0]    regAddr,
  input logic [WORD_W-1:0]   regWrData,
  input logic                engActiveSet,
  input logic                engDeadSet,
  input logic                flushDone,
  input logic [HALF_W-1:0]   statReg,
  input logic                runOut,
  input logic                flushReq,
  input logic                wakePulse,
  input logic [2*WORD_W-1:0] cmdPtr
);
  logic wakeWrite, runClrWrite;
  assign wakeWrite   = regWrEn && regAddr == IDX_CTL && regWrData[HALF_W+BIT_WAKE] && regWrData[BIT_WAKE];
  assign runClrWrite = regWrEn && regAddr == IDX_CTL && regWrData[HALF_W+BIT_RUN] && !regWrData[BIT_RUN];

  a_r7_wake_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> (!wakePulse || $past(wakeWrite)));

  a_r5_active_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statReg[BIT_ACTIVE]) |-> $past(engActiveSet && runOut));

  a_r4_dead_only_engine: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statReg[BIT_DEAD]) |-> $past(engDeadSet));

  a_r6_flush_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |=> !flushReq);

  a_r10_ptr_locked: assert property (@(posedge clk) disable iff (!rstN)
    (runOut || statReg[BIT_ACTIVE]) |=> $stable(cmdPtr));

  a_r8_run_clear: assert property (@(posedge clk) disable iff (!rstN)
    runClrWrite |=> !runOut);
endmodule

bind dma_chan_csr dma_csr_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regWrEn      (regWrEn),
  .regAddr      (regAddr),
  .regWrData    (regWrData),
  .engActiveSet (engActiveSet),
  .engDeadSet   (engDeadSet),
  .flushDone    (flushDone),
  .statReg      (statReg),
  .runOut       (runOut),
  .flushReq     (flushReq),
  .wakePulse    (wakePulse),
  .cmdPtr       (cmdPtr)
);

// File: tb/sim_dma_chan_csr.sv
module sim_dma_chan_csr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        engActiveSet = 1'b0, engIdle = 1'b0, engDeadSet = 1'b0;
  logic        engBtSet = 1'b0, engDevWe = 1'b0, flushDone = 1'b0;
  logic [7:0]  engDevData = '0;
  logic        runOut, pauseOut, flushReq, wakePulse;
  logic [63:0] cmdPtr;
  logic [31:0] irqSel, brSel, waitSel;

  int checks = 0;
  int errors = 0;
  logic rdStrobe = 1'b0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_csr u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .engActiveSet(engActiveSet), .engIdle(engIdle), .engDeadSet(engDeadSet),
    .engBtSet(engBtSet), .engDevWe(engDevWe), .engDevData(engDevData),
    .flushDone(flushDone), .runOut(runOut), .pauseOut(pauseOut),
    .flushReq(flushReq), .wakePulse(wakePulse), .cmdPtr(cmdPtr),
    .irqSel(irqSel), .brSel(brSel), .waitSel(waitSel)
  );

  task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops expected read values and compares
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rdStrobe && expQ.size() > 0) begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({32'b0, regRdData}, {32'b0, e}, t);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    regAddr = a;
    expQ.push_back(e);
    tagQ.push_back(tag);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: engActiveSet = 1'b1;
      1: engIdle = 1'b1;
      2: engDeadSet = 1'b1;
      3: engBtSet = 1'b1;
      4: engDevWe = 1'b1;
      default: flushDone = 1'b1;
    endcase
    @(negedge clk);
    {engActiveSet, engIdle, engDeadSet, engBtSet, engDevWe, flushDone} = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(4'd1, 32'h0, "R1 status");
    rd(4'd3, 32'h0, "R1 ptr");
    check({60'b0, runOut, pauseOut, flushReq, wakePulse}, 64'h0, "R1 outputs");

    // R2 map
    wr(4'd4, 32'h11223344);
    rd(4'd4, 32'h11223344, "R2 irq sel");
    check({32'b0, irqSel}, 64'h11223344, "R12 irqSel");
    wr(4'd12, 32'hCAFEF00D);
    rd(4'd12, 32'hCAFEF00D, "R2 idx12");
    wr(4'd10, 32'hFFFFFFFF);
    rd(4'd10, 32'h0, "R2 reserved");
    wr(4'd1, 32'hFFFFFFFF);
    rd(4'd1, 32'h0, "R2 status write ignored");
    rd(4'd0, 32'h0, "R2 control reads zero");

    // R10 pointer write when idle
    wr(4'd3, 32'h10000040);
    wr(4'd2, 32'h00000001);
    rd(4'd3, 32'h10000040, "R10 ptr lo idle");
    check(cmdPtr, 64'h00000001_10000040, "R12 cmdPtr");

    // R3 masked writes
    wr(4'd0, 32'h80008000);
    rd(4'd1, 32'h8000, "R3 set run");
    check({63'b0, runOut}, 64'h1, "R12 runOut");
    wr(4'd0, 32'h00FF00A5);
    rd(4'd1, 32'h80A5, "R3 dev field only");
    wr(4'd0, 32'h0000FFFF);
    rd(4'd1, 32'h80A5, "R3 empty mask");

    // R10 locked while running
    wr(4'd3, 32'h00002222);
    rd(4'd3, 32'h10000040, "R10 locked by run");

    // R5 active set while running
    pulse(0);
    rd(4'd1, 32'h84A5, "R5 active set");
    // R4 software cannot set dead
    wr(4'd0, 32'h0D000D00);
    rd(4'd1, 32'h84A5, "R4 no sw set");

    // R6 flush
    wr(4'd0, 32'h20002000);
    rd(4'd1, 32'hA4A5, "R6 flush set");
    check({63'b0, flushReq}, 64'h1, "R6 flushReq");
    pulse(5);
    rd(4'd1, 32'h84A5, "R6 flush done");
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd0; regWrData = 32'h20002000; flushDone = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; flushDone = 1'b0;
    check({63'b0, flushReq}, 64'h0, "R6 done wins");

    // R7 wake pulse
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd0; regWrData = 32'h10001000;
    @(posedge clk);
    #1 check({63'b0, wakePulse}, 64'h1, "R7 wake high");
    @(negedge clk);
    regWrEn = 1'b0;
    @(posedge clk);
    #1 check({63'b0, wakePulse}, 64'h0, "R7 wake self clear");
    rd(4'd1, 32'h84A5, "R7 status after wake");

    // R8 stop
    wr(4'd0, 32'hA0000000);
    rd(4'd1, 32'h04A5, "R8 stop keeps active");
    wr(4'd3, 32'h00003333);
    rd(4'd3, 32'h10000040, "R10 locked by active");
    pulse(1);
    rd(4'd1, 32'h00A5, "R8 idle ack");
    wr(4'd3, 32'h00003333);
    rd(4'd3, 32'h00003333, "R10 unlocked");

    // R5 active ignored without run
    pulse(0);
    rd(4'd1, 32'h00A5, "R5 no run no active");
    wr(4'd0, 32'hC000C000);
    check({63'b0, pauseOut}, 64'h1, "R12 pauseOut");
    pulse(0);
    pulse(2);
    rd(4'd1, 32'hC8A5, "R5 dead clears active");
    // R11 engine bits
    pulse(3);
    engDevData = 8'h3C;
    pulse(4);
    rd(4'd1, 32'hC93C, "R11 bt and dev");

    // R9 reset
    wr(4'd0, 32'hFC000000);
    rd(4'd1, 32'h013C, "R9 reset");
    check({62'b0, runOut, pauseOut}, 64'h0, "R9 outputs");
    // R4 clear-only BT
    wr(4'd0, 32'h01000100);
    rd(4'd1, 32'h013C, "R4 bt set ignored");
    wr(4'd0, 32'h01000000);
    rd(4'd1, 32'h003C, "R4 bt clear");

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule